// File: doc/BRIEF.md
# Timestep-Framed Output Capture Channel

This block is one outbound data channel between FPGA logic and a host. During each calculation step it collects 32-bit samples that arrive on a 33-bit input word whose top bit acts as a write strobe. When the step closes, everything collected is frozen into a readout bank. The host then drains that bank word by word while capture of the next step carries on into the other bank.

The channel has two capture modes. In register mode it keeps only the most recent sample of the step. In FIFO mode it keeps every strobed sample in arrival order, up to a fixed limit per step. Any write beyond that limit is dropped and raises a sticky overflow flag. The step boundary is normally the master sync pulse. When external sync is enabled, the boundary becomes an external pulse that must land within a window of 0 to 15 cycles after the master pulse. If no such pulse arrives, the step closes at the end of the window anyway. An external pulse that arrives outside the window is held and closes the following step when the next master pulse arrives. A sample strobed in the same cycle as the boundary is counted in the step that is closing.

Top module: `step_capture_channel`

## Requirements
- R1: `sample_in[32]` is the write strobe and `sample_in[31:0]` is the sample. A cycle with the strobe low stores nothing.
- R2: With `fifo_mode` = 0 (register mode), a step with at least one write is frozen with `rd_count` = 1, and `rd_data` equals the last sample written. A step with no write is frozen with `rd_count` = 0. Register mode never sets the overflow flag.
- R3: With `fifo_mode` = 1, `rd_count` equals the number of strobed cycles in the step, up to 254. The words read back are the samples in arrival order.
- R4: A sample strobed in the boundary cycle belongs to the step that closes in that cycle, not to the next step.
- R5: In the cycle after a boundary, `frame_ready` is 1, `rd_count` shows the frozen count, `rd_data` shows the first frozen word, and the capture count of the new step starts from zero. In every other cycle `frame_ready` is 0.
- R6: With `ext_sync_en` = 0, every `master_sync` cycle is a boundary and `ext_sync` has no effect.
- R7: With `ext_sync_en` = 1, an `ext_sync` pulse k cycles after `master_sync` (k = 0 to 15, with 0 meaning the same cycle) makes that cycle the boundary. No boundary occurs before that pulse.
- R8: With `ext_sync_en` = 1, an `ext_sync` pulse outside the window is held. The next `master_sync` cycle then becomes the boundary, and the held pulse is consumed.
- R9: With `ext_sync_en` = 1, if no `ext_sync` arrives, the cycle 15 cycles after `master_sync` is the boundary.
- R10: In FIFO mode, writes beyond 254 in one step are dropped and `ovf_flag` is set. The flag stays set across steps until a cycle with `ovf_ack` = 1 and no new drop clears it.
- R11: Each cycle with `rd_en` = 1 advances the read position by one word, up to `rd_count`. Once all words have been read, `rd_data` is 0.
- R12: A synchronous active-high `rst` clears the frozen count, the capture count, the held external pulse and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 selects FIFO capture, 0 selects register capture |
| ext_sync_en | input | 1 | 1 closes steps on the windowed external pulse |
| master_sync | input | 1 | Master step pulse |
| ext_sync | input | 1 | External step pulse |
| sample_in | input | 33 | Bit 32 is the write strobe, bits 31:0 are the sample |
| rd_en | input | 1 | Advance the read position by one word |
| rd_data | output | 32 | Word at the read position, 0 when the bank is fully read |
| rd_count | output | 8 | Number of words in the frozen bank |
| frame_ready | output | 1 | One-cycle pulse when a new bank is frozen |
| ovf_flag | output | 1 | Sticky flag for dropped FIFO writes |
| ovf_ack | input | 1 | Clears the overflow flag |

## Verification
The assertions check the following on every cycle:
- the per-step count never exceeds its limit;
- the capture count restarts after each boundary;
- the window offset stays within 1 to 15 while armed, and the end of the window always disarms the qualifier;
- the read position never passes the frozen count;
- the overflow flag stays set until it is acknowledged.

Only the bench scenarios can show the actual framing:
- which samples land in which step, including the one strobed in the boundary cycle;
- the exact boundary cycle for every window offset and for the fallback;
- that a late external pulse is deferred to the next master pulse;
- that the data read back is in order in both modes.

// File: rtl/stepcap_pkg.sv
package stepcap_pkg;

    localparam int SAMPLE_W_DEF    = 32;
    localparam int MAX_SAMPLES_DEF = 254;
    localparam int SYNC_WIN_DEF    = 15;

    typedef enum logic {
        QUAL_IDLE  = 1'b0,
        QUAL_ARMED = 1'b1
    } qual_state_e;

    function automatic int bits_for(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/stepcap_sync_qual.sv
module stepcap_sync_qual
    import stepcap_pkg::*;
#(
    parameter int WIN = SYNC_WIN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_en,
    input  logic master,
    input  logic ext,
    output logic close
);
    localparam int OFF_W = bits_for(WIN);

    qual_state_e      st;
    logic [OFF_W-1:0] off;
    logic             pend;

    always_comb begin
        close = 1'b0;
        if (!ext_en) begin
            close = master;
        end else if (st == QUAL_ARMED) begin
            close = ext || (off == OFF_W'(WIN));
        end else if (master) begin
            close = ext || pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ext_en) begin
            st   <= QUAL_IDLE;
            off  <= '0;
            pend <= 1'b0;
        end else begin
            case (st)
                QUAL_IDLE: begin
                    if (master) begin
                        if (ext || pend) begin
                            pend <= 1'b0;
                        end else begin
                            st  <= QUAL_ARMED;
                            off <= OFF_W'(1);
                        end
                    end else if (ext) begin
                        pend <= 1'b1;
                    end
                end
                QUAL_ARMED: begin
                    if (close) begin
                        st  <= QUAL_IDLE;
                        off <= '0;
                    end else begin
                        off <= off + 1'b1;
                    end
                end
                default: st <= QUAL_IDLE;
            endcase
        end
    end

    // R7: while armed the offset stays inside the window
    assert_window_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (st == QUAL_ARMED) |-> (off >= OFF_W'(1) && off <= OFF_W'(WIN)));

    // R9: reaching the window end always disarms the qualifier
    assert_fallback_close_R9: assert property (@(posedge clk) disable iff (rst)
        (ext_en && st == QUAL_ARMED && off == OFF_W'(WIN)) |=> (st == QUAL_IDLE));

    // R8: a held pulse is consumed by the next master pulse
    assert_pending_consumed_R8: assert property (@(posedge clk) disable iff (rst)
        (ext_en && st == QUAL_IDLE && pend && master) |=> !pend);

endmodule

// File: rtl/stepcap_store.sv
module stepcap_store
    import stepcap_pkg::*;
#(
    parameter int DW   = SAMPLE_W_DEF,
    parameter int MAXS = MAX_SAMPLES_DEF,
    localparam int AW  = bits_for(MAXS - 1),
    localparam int CW  = bits_for(MAXS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_mode,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          close,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word,
    output logic [CW-1:0] frz_count,
    output logic          dropped
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [2][DEPTH];
    logic          wb;
    logic [CW-1:0] wcnt;
    logic          accept;
    logic [AW-1:0] waddr;
    logic [CW-1:0] count_now;

    always_comb begin
        dropped   = wr_stb && fifo_mode && (wcnt >= CW'(MAXS));
        accept    = wr_stb && !dropped;
        waddr     = fifo_mode ? AW'(wcnt) : '0;
        count_now = wcnt;
        if (accept) begin
            count_now = fifo_mode ? (wcnt + 1'b1) : CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wb][waddr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb        <= 1'b0;
            wcnt      <= '0;
            frz_count <= '0;
        end else if (close) begin
            frz_count <= count_now;
            wb        <= ~wb;
            wcnt      <= '0;
        end else begin
            wcnt <= count_now;
        end
    end

    assign rd_word = mem[~wb][rd_addr];

    // R3: capture count never passes the per-step limit
    assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
        wcnt <= CW'(MAXS));

    // R5: a boundary restarts the new step from zero
    assert_step_restart_R5: assert property (@(posedge clk) disable iff (rst)
        close |=> (wcnt == '0));

    // R2: a register-mode write leaves exactly one held sample
    assert_reg_single_R2: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && wr_stb && !close) |=> (wcnt == CW'(1)));

endmodule

// File: rtl/stepcap_readout.sv
module stepcap_readout
    import stepcap_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          close,
    input  logic          rd_en,
    input  logic [CW-1:0] frz_count,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          frame_ready
);
    logic [CW-1:0] ptr;
    logic          have_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr         <= '0;
            frame_ready <= 1'b0;
        end else begin
            frame_ready <= close;
            if (close) begin
                ptr <= '0;
            end else if (rd_en && have_word) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    assign have_word = (ptr < frz_count);
    assign rd_addr   = AW'(ptr);
    assign rd_data   = have_word ? rd_word : '0;

    // R11: read position never passes the frozen count
    assert_ptr_bound_R11: assert property (@(posedge clk) disable iff (rst)
        ptr <= frz_count);

    // R5: a fresh bank is presented from its first word
    assert_fresh_bank_R5: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> (ptr == '0));

endmodule

// File: rtl/step_capture_channel.sv
module step_capture_channel
    import stepcap_pkg::*;
#(
    parameter int SAMPLE_W    = SAMPLE_W_DEF,
    parameter int MAX_SAMPLES = MAX_SAMPLES_DEF,
    parameter int SYNC_WIN    = SYNC_WIN_DEF,
    localparam int AW = bits_for(MAX_SAMPLES - 1),
    localparam int CW = bits_for(MAX_SAMPLES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fifo_mode,
    input  logic                ext_sync_en,
    input  logic                master_sync,
    input  logic                ext_sync,
    input  logic [SAMPLE_W:0]   sample_in,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic [CW-1:0]       rd_count,
    output logic                frame_ready,
    output logic                ovf_flag,
    input  logic                ovf_ack
);
    logic                close;
    logic                dropped;
    logic [AW-1:0]       rd_addr;
    logic [SAMPLE_W-1:0] rd_word;

    stepcap_sync_qual #(.WIN(SYNC_WIN)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .ext_en (ext_sync_en),
        .master (master_sync),
        .ext    (ext_sync),
        .close  (close)
    );

    stepcap_store #(.DW(SAMPLE_W), .MAXS(MAX_SAMPLES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode),
        .wr_stb    (sample_in[SAMPLE_W]),
        .wr_data   (sample_in[SAMPLE_W-1:0]),
        .close     (close),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .frz_count (rd_count),
        .dropped   (dropped)
    );

    stepcap_readout #(.DW(SAMPLE_W), .AW(AW), .CW(CW)) u_read (
        .clk         (clk),
        .rst         (rst),
        .close       (close),
        .rd_en       (rd_en),
        .frz_count   (rd_count),
        .rd_word     (rd_word),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .frame_ready (frame_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else if (dropped) begin
            ovf_flag <= 1'b1;
        end else if (ovf_ack) begin
            ovf_flag <= 1'b0;
        end
    end

    // R10: the overflow flag holds until acknowledged
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_ack) |=> ovf_flag);

    // R3: a frozen bank never reports more than the limit
    assert_frozen_cap_R3: assert property (@(posedge clk) disable iff (rst)
        rd_count <= CW'(MAX_SAMPLES));

endmodule

// File: tb/step_capture_channel_bench.sv
module step_capture_channel_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_mode = 1'b1;
    logic        ext_sync_en = 1'b0;
    logic        master_sync = 1'b0;
    logic        ext_sync = 1'b0;
    logic [32:0] sample_in = '0;
    logic        rd_en = 1'b0;
    logic        ovf_ack = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  rd_count;
    logic        frame_ready;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    step_capture_channel u_step_capture_channel (
        .clk         (clk),
        .rst         (rst),
        .fifo_mode   (fifo_mode),
        .ext_sync_en (ext_sync_en),
        .master_sync (master_sync),
        .ext_sync    (ext_sync),
        .sample_in   (sample_in),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_count    (rd_count),
        .frame_ready (frame_ready),
        .ovf_flag    (ovf_flag),
        .ovf_ack     (ovf_ack)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_n(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            sample_in = {1'b1, base + 32'(i)};
            step();
        end
        sample_in = '0;
    endtask

    task automatic close_master(input bit stb, input logic [31:0] d);
        master_sync = 1'b1;
        sample_in   = {stb, d};
        step();
        master_sync = 1'b0;
        sample_in   = '0;
    endtask

    task automatic drain(input int n, input logic [31:0] base, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, rd_data, base + 32'(i));
            rd_en = 1'b1;
            step();
        end
        rd_en = 1'b0;
        chk("R11 empty after drain", rd_data, 32'h0);
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        chk("R11 no advance past count", rd_data, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int sizes [8] = '{0, 1, 2, 3, 7, 31, 253, 254};
        repeat (3) step();
        rst = 1'b0;
        step();
        // R12 reset state
        chk("R12 count after reset", 32'(rd_count), 0);
        chk("R12 ovf after reset", 32'(ovf_flag), 0);
        chk("R5 no frame after reset", 32'(frame_ready), 0);
        chk("R11 data after reset", rd_data, 0);

        // R3 / R6: FIFO sweep of step sizes on master boundary
        fifo_mode = 1'b1;
        foreach (sizes[s]) begin
            int n = sizes[s];
            write_n(n, 32'(n) << 16);
            chk("R5 no frame before boundary", 32'(frame_ready), 0);
            close_master(1'b0, 32'h0);
            chk("R5 frame pulse", 32'(frame_ready), 1);
            chk("R3 fifo count", 32'(rd_count), 32'(n));
            drain(n, 32'(n) << 16, "R3 fifo order");
            chk("R5 single frame pulse", 32'(frame_ready), 0);
        end

        // R1: strobe-low cycles store nothing
        for (int i = 0; i < 10; i++) begin
            sample_in = {1'(i % 2), 32'hDEAD_0000 + 32'(i)};
            step();
        end
        sample_in = '0;
        close_master(1'b0, 32'h0);
        chk("R1 strobe count", 32'(rd_count), 5);
        for (int i = 0; i < 5; i++) begin
            chk("R1 strobed data", rd_data, 32'hDEAD_0001 + 32'(2 * i));
            rd_en = 1'b1;
            step();
        end
        rd_en = 1'b0;

        // R4: coincident sample belongs to ending step
        write_n(3, 32'h500);
        close_master(1'b1, 32'h503);
        chk("R4 coincident count", 32'(rd_count), 4);
        drain(4, 32'h500, "R4 coincident data");
        close_master(1'b0, 32'h0);
        chk("R4 not carried forward", 32'(rd_count), 0);

        // R10: overflow drops and sticky flag
        write_n(260, 32'h0);
        chk("R10 ovf set", 32'(ovf_flag), 1);
        close_master(1'b0, 32'h0);
        chk("R10 capped count", 32'(rd_count), 254);
        chk("R10 ovf sticky across step", 32'(ovf_flag), 1);
        drain(254, 32'h0, "R10 kept data");
        chk("R10 ovf still set", 32'(ovf_flag), 1);
        ovf_ack = 1'b1;
        step();
        ovf_ack = 1'b0;
        chk("R10 ovf cleared by ack", 32'(ovf_flag), 0);

        // R2: register mode
        fifo_mode = 1'b0;
        write_n(5, 32'h700);
        close_master(1'b0, 32'h0);
        chk("R2 reg count", 32'(rd_count), 1);
        chk("R2 reg last data", rd_data, 32'h704);
        close_master(1'b0, 32'h0);
        chk("R2 reg empty step", 32'(rd_count), 0);
        write_n(2, 32'h800);
        close_master(1'b1, 32'h900);
        chk("R4 reg coincident data", rd_data, 32'h900);
        write_n(300, 32'h1000);
        close_master(1'b0, 32'h0);
        chk("R2 reg no overflow", 32'(ovf_flag), 0);
        chk("R2 reg long step data", rd_data, 32'h1000 + 299);

        // R6: external pulse ignored while disabled
        fifo_mode = 1'b1;
        write_n(2, 32'h40);
        ext_sync = 1'b1;
        step();
        ext_sync = 1'b0;
        step();
        chk("R6 ext ignored no frame", 32'(frame_ready), 0);
        close_master(1'b0, 32'h0);
        chk("R6 master closes", 32'(rd_count), 2);

        // R7: sweep of external offsets 0..15
        ext_sync_en = 1'b1;
        for (int k = 0; k <= 15; k++) begin
            for (int j = 0; j <= k; j++) begin
                master_sync = (j == 0);
                ext_sync    = (j == k);
                sample_in   = {1'b1, 32'(k) * 32'h1000 + 32'(j)};
                step();
                if (j < k) chk("R7 no early boundary", 32'(frame_ready), 0);
            end
            master_sync = 1'b0;
            ext_sync    = 1'b0;
            sample_in   = '0;
            chk("R7 boundary at ext", 32'(frame_ready), 1);
            chk("R7 count for offset", 32'(rd_count), 32'(k + 1));
            drain(k + 1, 32'(k) * 32'h1000, "R7 data for offset");
        end

        // R9 fallback, then R8 late pulse held
        for (int j = 0; j <= 20; j++) begin
            master_sync = (j == 0);
            ext_sync    = (j == 18);
            sample_in   = {1'b1, 32'h9000 + 32'(j)};
            step();
            if (j == 14) chk("R9 no boundary before window end", 32'(frame_ready), 0);
            if (j == 15) begin
                chk("R9 fallback boundary", 32'(frame_ready), 1);
                chk("R9 fallback count", 32'(rd_count), 16);
            end
        end
        master_sync = 1'b0;
        ext_sync    = 1'b0;
        sample_in   = '0;
        repeat (3) step();
        chk("R8 held pulse no frame", 32'(frame_ready), 0);
        close_master(1'b0, 32'h0);
        chk("R8 held pulse closes at master", 32'(frame_ready), 1);
        chk("R8 late samples count", 32'(rd_count), 5);
        drain(5, 32'h9010, "R8 late samples data");
        // held pulse consumed: next master arms the window again
        master_sync = 1'b1;
        step();
        master_sync = 1'b0;
        chk("R8 pulse consumed", 32'(frame_ready), 0);
        step();
        ext_sync = 1'b1;
        step();
        ext_sync = 1'b0;
        chk("R7 boundary at offset 2", 32'(frame_ready), 1);
        chk("R7 empty step", 32'(rd_count), 0);

        // R12: reset mid-step clears everything
        ext_sync_en = 1'b0;
        write_n(3, 32'h77);
        close_master(1'b0, 32'h0);
        write_n(300, 32'h0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R12 count cleared", 32'(rd_count), 0);
        chk("R12 ovf cleared", 32'(ovf_flag), 0);
        close_master(1'b0, 32'h0);
        chk("R12 capture cleared", 32'(rd_count), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule